// File: doc/BRIEF.md
# Per-Port Auto-Partition Controller

This block guards one port of a multi-port repeater against a segment that keeps colliding. It watches the end of every packet received on the port and counts how many of them in a row carried a collision. When that run reaches a selectable limit (32 or 64), the port is isolated: its receive path is gated off so that it can no longer inject traffic into the repeater, while traffic sent out of the port continues unchanged.

An isolated port is restored when the repeater sends it a clean packet of at least minimum size. Transmit activity is timed in nibble clocks; a burst of 128 or more nibbles (512 bits) that ends without a collision reconnects the port. Shorter bursts, and bursts that collide, leave the port isolated. A disable input switches the whole function off and holds the port connected.

Collision detection and packet framing are done elsewhere; this block receives a one-cycle end-of-packet pulse with a collision flag for receive, and a transmit-activity level with a collision flag for transmit.

Top module: `autopart_top`

## Requirements
- R1: After reset (asynchronous, active low on `rst_n`), `partitioned` is 0 and `rx_enable` is 1, whatever state the block was in before.
- R2: With `lim_sel` = 0, the clock edge that samples the 32nd consecutive `rx_pkt_end` pulse with `rx_pkt_col` = 1 sets `partitioned`; after 31 such pulses it stays 0.
- R3: With `lim_sel` = 1, the limit is 64 consecutive collided receive packets; 63 leave the port connected and the 64th partitions it.
- R4: An `rx_pkt_end` pulse with `rx_pkt_col` = 0 clears the run of consecutive collisions, so counting restarts from zero.
- R5: `rx_enable` is the inverse of `partitioned` in every cycle.
- R6: While partitioned, a transmit burst (`tx_active` high on 128 or more consecutive clock edges) with `tx_col` low on all of them clears `partitioned` at the first edge that samples `tx_active` low.
- R7: A transmit burst of 127 or fewer nibble clocks, or one in which `tx_col` is sampled high at least once, leaves the port partitioned; `partitioned` never falls while `tx_active` is high.
- R8: Receive packet ends seen while partitioned are ignored, and the collision run restarts from zero after reconnection.
- R9: While `part_dis` is 1, `partitioned` is 0 from the next edge on and receive collisions are not counted; the collision run is zero when `part_dis` returns to 0.
- R10: The limit comparison is "reached or exceeded": lowering `lim_sel` from 1 to 0 while the run is already above 32 partitions the port at the next collided receive packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_pkt_end | input | 1 | One-cycle pulse at the end of each received packet |
| rx_pkt_col | input | 1 | Packet just ended saw a collision (valid with `rx_pkt_end`) |
| tx_active | input | 1 | High for each nibble clock of transmission out of the port |
| tx_col | input | 1 | Collision during the current transmit nibble |
| lim_sel | input | 1 | Consecutive-collision limit: 0 selects 32, 1 selects 64 |
| part_dis | input | 1 | 1 disables isolation and holds the port connected |
| partitioned | output | 1 | Port is isolated |
| rx_enable | output | 1 | Receive path gate, low while isolated |

## Verification
The properties assume `rx_pkt_end` arrives as single-cycle pulses whose collision flag is meaningful only in that cycle, and that `tx_col` is raised only while `tx_active` is high, so a burst ends exactly when `tx_active` is sampled low. The stimulus tasks raise each packet-end pulse for one cycle and drop both flags afterward, and they drive `tx_col` only together with `tx_active`. All inputs change on the falling clock edge, so every rising edge samples a settled, legal combination.

// File: rtl/autopart_pkg.sv
package autopart_pkg;

    typedef enum logic {
        PORT_LINKED   = 1'b0,
        PORT_ISOLATED = 1'b1
    } port_state_e;

endpackage

// File: rtl/autopart_colrun.sv
module autopart_colrun #(
    parameter int LIM_LO = 32,
    parameter int LIM_HI = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_end,
    input  logic pkt_col,
    input  logic hold_clear,
    input  logic lim_sel,
    output logic trip
);
    localparam int CW = $clog2(LIM_HI + 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } run_s;

    run_s cur_q, nxt_d;
    logic [CW:0] inc;
    logic [CW:0] lim;

    always_comb begin
        nxt_d = cur_q;
        trip  = 1'b0;
        inc   = {1'b0, cur_q.run} + 1'b1;
        lim   = lim_sel ? (CW+1)'(LIM_HI) : (CW+1)'(LIM_LO);
        if (hold_clear) begin
            nxt_d.run = '0;
        end else if (pkt_end) begin
            if (pkt_col) begin
                if (inc >= lim) begin
                    trip      = 1'b1;
                    nxt_d.run = '0;
                end else begin
                    nxt_d.run = inc[CW-1:0];
                end
            end else begin
                nxt_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/autopart_txmeter.sv
module autopart_txmeter #(
    parameter int MIN_NIB = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic meter_en,
    input  logic tx_active,
    input  logic tx_col,
    output logic clean_done
);
    localparam int LW = $clog2(MIN_NIB + 1);

    typedef struct packed {
        logic [LW-1:0] len;
        logic          hit;
        logic          busy;
    } meter_s;

    meter_s cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        clean_done = 1'b0;
        if (tx_active) begin
            nxt_d.busy = 1'b1;
            if (meter_en && (cur_q.len < LW'(MIN_NIB))) begin
                nxt_d.len = cur_q.len + 1'b1;
            end
            if (tx_col) begin
                nxt_d.hit = 1'b1;
            end
        end else begin
            if (cur_q.busy) begin
                clean_done = meter_en && !cur_q.hit && (cur_q.len >= LW'(MIN_NIB));
            end
            nxt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/autopart_state.sv
module autopart_state
    import autopart_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic disable_in,
    input  logic trip,
    input  logic reconnect,
    output logic isolated
);
    typedef struct packed {
        port_state_e st;
    } st_s;

    st_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (disable_in) begin
            nxt_d.st = PORT_LINKED;
        end else begin
            case (cur_q.st)
                PORT_LINKED:   if (trip)      nxt_d.st = PORT_ISOLATED;
                PORT_ISOLATED: if (reconnect) nxt_d.st = PORT_LINKED;
                default:                      nxt_d.st = PORT_LINKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: PORT_LINKED};
        else        cur_q <= nxt_d;
    end

    assign isolated = (cur_q.st == PORT_ISOLATED);

endmodule

// File: rtl/autopart_top.sv
module autopart_top #(
    parameter int LIM_LO  = 32,
    parameter int LIM_HI  = 64,
    parameter int MIN_NIB = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pkt_end,
    input  logic rx_pkt_col,
    input  logic tx_active,
    input  logic tx_col,
    input  logic lim_sel,
    input  logic part_dis,
    output logic partitioned,
    output logic rx_enable
);
    logic isolated;
    logic trip;
    logic clean_done;

    autopart_colrun #(
        .LIM_LO (LIM_LO),
        .LIM_HI (LIM_HI)
    ) i_colrun (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_end    (rx_pkt_end),
        .pkt_col    (rx_pkt_col),
        .hold_clear (part_dis | isolated),
        .lim_sel    (lim_sel),
        .trip       (trip)
    );

    autopart_txmeter #(
        .MIN_NIB (MIN_NIB)
    ) i_txmeter (
        .clk        (clk),
        .rst_n      (rst_n),
        .meter_en   (isolated),
        .tx_active  (tx_active),
        .tx_col     (tx_col),
        .clean_done (clean_done)
    );

    autopart_state i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .disable_in (part_dis),
        .trip       (trip),
        .reconnect  (clean_done),
        .isolated   (isolated)
    );

    assign partitioned = isolated;
    assign rx_enable   = ~isolated;

endmodule

// File: rtl/autopart_chk.sv
module autopart_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_pkt_end,
    input logic rx_pkt_col,
    input logic tx_active,
    input logic part_dis,
    input logic partitioned
);
    AST_DIS_CONNECTS: assert property (@(posedge clk) disable iff (!rst_n)
        part_dis |=> !partitioned); // R9

    AST_CLEAN_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!partitioned && rx_pkt_end && !rx_pkt_col) |=> !partitioned); // R4

    AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!partitioned && !(rx_pkt_end && rx_pkt_col)) |=> !partitioned); // R2

    AST_HOLD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (partitioned && tx_active && !part_dis) |=> partitioned); // R7

    AST_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (partitioned && !tx_active && !part_dis) |=> partitioned || $past(tx_active, 2)); // R6

endmodule

bind autopart_top autopart_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_pkt_end  (rx_pkt_end),
    .rx_pkt_col  (rx_pkt_col),
    .tx_active   (tx_active),
    .part_dis    (part_dis),
    .partitioned (partitioned)
);

// File: tb/test_autopart_top.sv
`timescale 1ns/1ps
module test_autopart_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pkt_end = 1'b0;
    logic rx_pkt_col = 1'b0;
    logic tx_active = 1'b0;
    logic tx_col = 1'b0;
    logic lim_sel = 1'b0;
    logic part_dis = 1'b0;
    logic partitioned;
    logic rx_enable;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    autopart_top i_autopart_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_pkt_end  (rx_pkt_end),
        .rx_pkt_col  (rx_pkt_col),
        .tx_active   (tx_active),
        .tx_col      (tx_col),
        .lim_sel     (lim_sel),
        .part_dis    (part_dis),
        .partitioned (partitioned),
        .rx_enable   (rx_enable)
    );

    // Row: {op[1:0], count[7:0], col, sel, expected partitioned}
    // op 0 = receive packet ends, 1 = transmit burst, 2 = disable pulse
    localparam int NROW = 19;
    localparam logic [12:0] TBL [NROW] = '{
        {2'd0, 8'd31,  1'b1, 1'b0, 1'b0},  // R2 31 collisions, still linked
        {2'd0, 8'd1,   1'b1, 1'b0, 1'b1},  // R2 32nd collision isolates
        {2'd1, 8'd127, 1'b0, 1'b0, 1'b1},  // R7 short burst
        {2'd1, 8'd200, 1'b1, 1'b0, 1'b1},  // R7 long burst with collision
        {2'd1, 8'd128, 1'b0, 1'b0, 1'b0},  // R6 clean 128 nibbles reconnects
        {2'd0, 8'd31,  1'b1, 1'b0, 1'b0},  // R4 build run again
        {2'd0, 8'd1,   1'b0, 1'b0, 1'b0},  // R4 clean packet clears run
        {2'd0, 8'd31,  1'b1, 1'b0, 1'b0},  // R4 run restarted
        {2'd0, 8'd1,   1'b1, 1'b0, 1'b1},  // R2 isolate
        {2'd0, 8'd20,  1'b1, 1'b0, 1'b1},  // R8 ignored while isolated
        {2'd1, 8'd128, 1'b0, 1'b0, 1'b0},  // R6 reconnect
        {2'd0, 8'd31,  1'b1, 1'b0, 1'b0},  // R8 run fresh after reconnect
        {2'd0, 8'd1,   1'b1, 1'b0, 1'b1},  // R8 isolate at 32
        {2'd2, 8'd1,   1'b0, 1'b0, 1'b0},  // R9 disable pulse connects
        {2'd0, 8'd63,  1'b1, 1'b1, 1'b0},  // R3 63 collisions at limit 64
        {2'd0, 8'd1,   1'b1, 1'b1, 1'b1},  // R3 64th isolates
        {2'd1, 8'd128, 1'b0, 1'b1, 1'b0},  // R6 reconnect
        {2'd0, 8'd40,  1'b1, 1'b1, 1'b0},  // R10 run of 40 under limit 64
        {2'd0, 8'd1,   1'b1, 1'b0, 1'b1}   // R10 limit lowered, 41 >= 32
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic rx_events(input int n, input logic col);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_pkt_end = 1'b1;
            rx_pkt_col = col;
        end
        @(negedge clk);
        rx_pkt_end = 1'b0;
        rx_pkt_col = 1'b0;
    endtask

    task automatic tx_burst(input int n, input logic col);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_active = 1'b1;
            tx_col    = col;
        end
        @(negedge clk);
        tx_active = 1'b0;
        tx_col    = 1'b0;
        @(negedge clk);
    endtask

    task automatic dis_pulse();
        @(negedge clk);
        part_dis = 1'b1;
        @(negedge clk);
        part_dis = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(partitioned, 1'b0, "R1 partitioned after reset");
        check(rx_enable,   1'b1, "R1 rx_enable after reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int r = 0; r < NROW; r++) begin
            logic [1:0] op;
            logic [7:0] cnt;
            logic       col;
            logic       exp;
            {op, cnt, col, lim_sel, exp} = TBL[r];
            case (op)
                2'd0:    rx_events(int'(cnt), col);
                2'd1:    tx_burst(int'(cnt), col);
                default: dis_pulse();
            endcase
            check(partitioned, exp, $sformatf("row %0d partitioned", r));
            check(rx_enable, ~exp, $sformatf("R5 row %0d rx_enable", r));
        end

        // R9: collisions while disabled are neither acted on nor counted
        lim_sel = 1'b0;
        @(negedge clk);
        part_dis = 1'b1;
        rx_events(40, 1'b1);
        check(partitioned, 1'b0, "R9 held connected while disabled");
        part_dis = 1'b0;
        rx_events(31, 1'b1);
        check(partitioned, 1'b0, "R9 run zero after disable");
        rx_events(1, 1'b1);
        check(partitioned, 1'b1, "R9 isolates at limit after disable");

        // R7: burst with a single collision nibble in the middle
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            tx_active = 1'b1;
            tx_col    = (i == 75);
        end
        @(negedge clk);
        tx_active = 1'b0;
        tx_col    = 1'b0;
        @(negedge clk);
        check(partitioned, 1'b1, "R7 one collision nibble keeps isolation");

        // R1: reset from the isolated state
        rst_n = 1'b0;
        #1;
        check(partitioned, 1'b0, "R1 reset while isolated");
        check(rx_enable,   1'b1, "R1 rx_enable restored by reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule